// File: doc/BRIEF.md
# Multi-Mode DMA Request Controller

This block is the request and transfer-start logic for one buffered external-port DMA channel. A three-bit mode code picks how transfers begin. In slave mode the channel asks an outside host to move data. In master mode the channel starts bus cycles by itself. In paced master mode it starts them only while an external request line is high. In the two handshake modes it answers each rising edge of the external request with a grant that lasts until the bus acknowledges.

The block does not keep a word count of its own. It reads the current count, pulses a decrement when a transfer completes, and pulses a done flag on the transfer that takes the count from one to zero. The code bits are master (bit 2), handshake (bit 1) and external-handshake (bit 0). Codes 001, 101 and 111 are reserved. On a channel built without handshake capability, codes 010, 011 and 110 also count as reserved.

Top module: `dma_req_chan`

## Requirements
- R1: With mode 000 and the channel enabled, `hostReq` goes high one clock after the buffer becomes ready. In this mode no bus strobe and no grant is ever raised.
- R2: The buffer is ready when `dirTx`=0 and `bufEmpty`=0, or when `dirTx`=1 and `bufFull`=0. A master or paced transfer drives `wrStrobe` when `dirTx`=0 and `rdStrobe` when `dirTx`=1.
- R3: With mode 100, a transfer starts one clock after the buffer is ready and `wordCount` is non-zero. With a zero count, no transfer starts.
- R4: The strobe stays high until `busAck`. When `busAck` arrives in the same cycle and the count is above one with the buffer still ready, the next transfer follows with no idle cycle.
- R5: `cntDec` is high in the same cycle that `busAck` completes an active transfer on a non-zero count. `donePulse` is high only in that same cycle, and only when `wordCount` is 1.
- R6: With mode 110, a transfer starts only while `extReq` is high. Its strobe is shown only while `extReq` is high, and `busAck` completes it only while `extReq` is high.
- R7: With mode 010, a rising edge of `extReq` while the buffer is ready raises `grantOut` one clock later, until `busAck`. Each rising edge gives exactly one grant, and the grant raises no read or write strobe.
- R8: With mode 011, a rising edge of `extReq` raises `grantOut` whatever the buffer flags are.
- R9: For codes 001, 101 and 111, every output stays low.
- R10: With `HS_CAPABLE`=0, codes 010, 011 and 110 behave as reserved. Mode 100 still works.
- R11: With `dirTx`=1, the channel enabled, a non-reserved mode and `bufFull`=0, `fillReq` goes high one clock later, without any external request.
- R12: Clearing `chanEnable` removes `cntDec` at once and brings every registered output low at the next clock.
- R13: At most one of `rdStrobe`, `wrStrobe` and `grantOut` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCode | input | 3 | Master, handshake and external-handshake bits |
| chanEnable | input | 1 | Channel enable |
| dirTx | input | 1 | 1 = transmit, 0 = receive |
| bufFull | input | 1 | Channel buffer full |
| bufEmpty | input | 1 | Channel buffer empty |
| wordCount | input | COUNT_W | Current remaining word count |
| extReq | input | 1 | External request, active high |
| busAck | input | 1 | Bus acknowledge, ends the current transfer |
| hostReq | output | 1 | DMA request toward the host (slave mode) |
| grantOut | output | 1 | Grant for handshake transfers |
| rdStrobe | output | 1 | Bus read strobe |
| wrStrobe | output | 1 | Bus write strobe |
| cntDec | output | 1 | Decrement the word count |
| donePulse | output | 1 | Last word transferred |
| fillReq | output | 1 | Ask the internal side to fill the buffer |

## Verification
The bench builds two copies of the block on shared inputs. The first has `HS_CAPABLE`=1 and reaches all five modes, including back-to-back master cycles and paced cycles gated by `extReq`. The second has `HS_CAPABLE`=0 and shows the handshake and paced codes falling back to idle while master mode still runs. `COUNT_W` stays at 16, since only the values 0, 1 and above one matter.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [2:0] {
    KIND_OFF,
    KIND_SLAVE,
    KIND_MASTER,
    KIND_PACED,
    KIND_HS,
    KIND_XHS
  } chanKind_t;

  typedef struct packed {
    logic busyNext;
    logic grantNext;
    logic pacedNext;
    logic hostReqNext;
    logic fillReqNext;
    logic complete;
  } ctlStrobe_t;

  function automatic chanKind_t decodeMode(input logic [2:0] code, input logic hsOk);
    chanKind_t k;
    case (code)
      3'b000:  k = KIND_SLAVE;
      3'b100:  k = KIND_MASTER;
      3'b110:  k = hsOk ? KIND_PACED : KIND_OFF;
      3'b010:  k = hsOk ? KIND_HS : KIND_OFF;
      3'b011:  k = hsOk ? KIND_XHS : KIND_OFF;
      default: k = KIND_OFF;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter bit HS_CAPABLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeCode,
  input  logic       chanEnable,
  input  logic       dirTx,
  input  logic       bufFull,
  input  logic       bufEmpty,
  input  logic       extReq,
  input  logic       busAck,
  input  logic       busyQ,
  input  logic       cntNonZero,
  input  logic       cntIsOne,
  output ctlStrobe_t ctl
);

  chanKind_t kind;
  logic extReqPrev;
  logic extRise;
  logic bufReady;
  logic canStart;
  logic canRestart;
  logic strobeLive;

  assign kind       = decodeMode(modeCode, HS_CAPABLE);
  assign bufReady   = dirTx ? !bufFull : !bufEmpty;
  assign extRise    = extReq && !extReqPrev;
  assign strobeLive = (kind != KIND_PACED) || extReq;

  always_ff @(posedge clk) begin
    if (!rstN) extReqPrev <= 1'b0;
    else       extReqPrev <= extReq;
  end

  always_comb begin
    canStart   = 1'b0;
    canRestart = 1'b0;
    case (kind)
      KIND_MASTER: begin
        canStart   = bufReady && cntNonZero;
        canRestart = bufReady && cntNonZero && !cntIsOne;
      end
      KIND_PACED: begin
        canStart   = bufReady && cntNonZero && extReq;
        canRestart = bufReady && cntNonZero && !cntIsOne && extReq;
      end
      KIND_HS:  canStart = bufReady && extRise;
      KIND_XHS: canStart = extRise;
      default: ;
    endcase
  end

  always_comb begin
    ctl.complete = chanEnable && busyQ && busAck && strobeLive;
    if (!chanEnable || kind == KIND_OFF || kind == KIND_SLAVE) ctl.busyNext = 1'b0;
    else if (!busyQ)                                           ctl.busyNext = canStart;
    else if (ctl.complete)                                     ctl.busyNext = canRestart;
    else                                                       ctl.busyNext = 1'b1;
    ctl.grantNext   = (kind == KIND_HS) || (kind == KIND_XHS);
    ctl.pacedNext   = (kind == KIND_PACED);
    ctl.hostReqNext = chanEnable && (kind == KIND_SLAVE) && bufReady;
    ctl.fillReqNext = chanEnable && dirTx && !bufFull && (kind != KIND_OFF);
  end

endmodule

// File: rtl/dma_req_datapath.sv
module dma_req_datapath
  import dma_req_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic               dirTx,
  input  logic               extReq,
  input  logic [COUNT_W-1:0] wordCount,
  output logic               busyQ,
  output logic               cntNonZero,
  output logic               cntIsOne,
  output logic               hostReq,
  output logic               grantOut,
  output logic               rdStrobe,
  output logic               wrStrobe,
  output logic               cntDec,
  output logic               donePulse,
  output logic               fillReq
);

  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic grantQ, pacedQ, hostReqQ, fillReqQ;
  logic busStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      grantQ   <= 1'b0;
      pacedQ   <= 1'b0;
      hostReqQ <= 1'b0;
      fillReqQ <= 1'b0;
    end else begin
      busyQ    <= ctl.busyNext;
      grantQ   <= ctl.busyNext && ctl.grantNext;
      pacedQ   <= ctl.busyNext && ctl.pacedNext;
      hostReqQ <= ctl.hostReqNext;
      fillReqQ <= ctl.fillReqNext;
    end
  end

  assign cntNonZero = (wordCount != '0);
  assign cntIsOne   = (wordCount == ONE);
  assign busStrobe  = busyQ && !grantQ && (!pacedQ || extReq);

  assign hostReq   = hostReqQ;
  assign fillReq   = fillReqQ;
  assign grantOut  = busyQ && grantQ;
  assign rdStrobe  = busStrobe && dirTx;
  assign wrStrobe  = busStrobe && !dirTx;
  assign cntDec    = ctl.complete && cntNonZero;
  assign donePulse = cntDec && cntIsOne;

endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
  import dma_req_pkg::*;
#(
  parameter int COUNT_W    = 16,
  parameter bit HS_CAPABLE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         modeCode,
  input  logic               chanEnable,
  input  logic               dirTx,
  input  logic               bufFull,
  input  logic               bufEmpty,
  input  logic [COUNT_W-1:0] wordCount,
  input  logic               extReq,
  input  logic               busAck,
  output logic               hostReq,
  output logic               grantOut,
  output logic               rdStrobe,
  output logic               wrStrobe,
  output logic               cntDec,
  output logic               donePulse,
  output logic               fillReq
);

  ctlStrobe_t ctl;
  logic busyQ, cntNonZero, cntIsOne;

  dma_req_ctrl #(.HS_CAPABLE(HS_CAPABLE)) ctrlInst (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .chanEnable(chanEnable),
    .dirTx(dirTx), .bufFull(bufFull), .bufEmpty(bufEmpty), .extReq(extReq),
    .busAck(busAck), .busyQ(busyQ), .cntNonZero(cntNonZero),
    .cntIsOne(cntIsOne), .ctl(ctl)
  );

  dma_req_datapath #(.COUNT_W(COUNT_W)) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dirTx(dirTx), .extReq(extReq),
    .wordCount(wordCount), .busyQ(busyQ), .cntNonZero(cntNonZero),
    .cntIsOne(cntIsOne), .hostReq(hostReq), .grantOut(grantOut),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .cntDec(cntDec),
    .donePulse(donePulse), .fillReq(fillReq)
  );

endmodule

// File: rtl/dma_req_chan_chk.sv
module dma_req_chan_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         modeCode,
  input logic               chanEnable,
  input logic [COUNT_W-1:0] wordCount,
  input logic               extReq,
  input logic               hostReq,
  input logic               grantOut,
  input logic               rdStrobe,
  input logic               wrStrobe,
  input logic               cntDec,
  input logic               donePulse,
  input logic               fillReq
);

  logic codeReserved;
  assign codeReserved = (modeCode == 3'b001) || (modeCode == 3'b101) || (modeCode == 3'b111);

  assert_strobe_exclusive_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStrobe, wrStrobe, grantOut}));

  assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    codeReserved |=> !(rdStrobe || wrStrobe || grantOut));

  assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |=> !(hostReq || grantOut || rdStrobe || wrStrobe || fillReq));

  assert_disable_no_dec_R12: assert property (@(posedge clk) disable iff (!rstN)
    !chanEnable |-> !cntDec);

  assert_done_with_dec_R5: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> cntDec);

  assert_zero_count_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'b100 && wordCount == '0 && !rdStrobe && !wrStrobe && !grantOut)
      |=> !(rdStrobe || wrStrobe));

  assert_slave_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    hostReq |-> $past(modeCode == 3'b000 && chanEnable));

  assert_paced_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStrobe || wrStrobe) && $past(modeCode == 3'b110)) |-> extReq);

endmodule

bind dma_req_chan dma_req_chan_chk #(.COUNT_W(COUNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .modeCode(modeCode), .chanEnable(chanEnable),
  .wordCount(wordCount), .extReq(extReq), .hostReq(hostReq),
  .grantOut(grantOut), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
  .cntDec(cntDec), .donePulse(donePulse), .fillReq(fillReq)
);

// File: tb/dma_req_chan_test.sv
module dma_req_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int COUNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeCode = 3'b000;
  logic chanEnable = 1'b0, dirTx = 1'b0, bufFull = 1'b0, bufEmpty = 1'b1;
  logic [COUNT_W-1:0] wordCount = '0;
  logic extReq = 1'b0, busAck = 1'b0;

  logic hostReq, grantOut, rdStrobe, wrStrobe, cntDec, donePulse, fillReq;
  logic nhHostReq, nhGrant, nhRd, nhWr, nhDec, nhDone, nhFill;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_chan #(.COUNT_W(COUNT_W), .HS_CAPABLE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .chanEnable(chanEnable),
    .dirTx(dirTx), .bufFull(bufFull), .bufEmpty(bufEmpty), .wordCount(wordCount),
    .extReq(extReq), .busAck(busAck), .hostReq(hostReq), .grantOut(grantOut),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .cntDec(cntDec),
    .donePulse(donePulse), .fillReq(fillReq)
  );

  dma_req_chan #(.COUNT_W(COUNT_W), .HS_CAPABLE(1'b0)) uutNoHs (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .chanEnable(chanEnable),
    .dirTx(dirTx), .bufFull(bufFull), .bufEmpty(bufEmpty), .wordCount(wordCount),
    .extReq(extReq), .busAck(busAck), .hostReq(nhHostReq), .grantOut(nhGrant),
    .rdStrobe(nhRd), .wrStrobe(nhWr), .cntDec(nhDec),
    .donePulse(nhDone), .fillReq(nhFill)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleChan();
    chanEnable = 1'b0; extReq = 1'b0; busAck = 1'b0;
    tick();
  endtask

  task automatic testReset();
    check("R12", "reset hostReq", hostReq, 1'b0);
    check("R12", "reset strobes", rdStrobe | wrStrobe | grantOut, 1'b0);
    check("R12", "reset fillReq", fillReq, 1'b0);
  endtask

  task automatic testSlave();
    modeCode = 3'b000; dirTx = 1'b0; bufEmpty = 1'b0; bufFull = 1'b0; chanEnable = 1'b1;
    tick();
    check("R1", "slave rx ready", hostReq, 1'b1);
    check("R1", "slave no strobe", rdStrobe | wrStrobe | grantOut, 1'b0);
    bufEmpty = 1'b1;
    tick();
    check("R2", "slave rx empty", hostReq, 1'b0);
    dirTx = 1'b1; bufFull = 1'b0;
    tick();
    check("R2", "slave tx room", hostReq, 1'b1);
    bufFull = 1'b1;
    tick();
    check("R2", "slave tx full", hostReq, 1'b0);
    idleChan();
  endtask

  task automatic testMaster();
    modeCode = 3'b100; dirTx = 1'b0; bufEmpty = 1'b0; bufFull = 1'b0;
    wordCount = 16'd2; chanEnable = 1'b1;
    tick();
    check("R3", "master start wr", wrStrobe, 1'b1);
    check("R2", "master rx no rd", rdStrobe, 1'b0);
    check("R13", "master no grant", grantOut, 1'b0);
    tick();
    check("R4", "held during wait", wrStrobe, 1'b1);
    check("R5", "no dec without ack", cntDec, 1'b0);
    busAck = 1'b1; #1;
    check("R5", "dec on ack", cntDec, 1'b1);
    check("R5", "no done at 2", donePulse, 1'b0);
    tick();
    wordCount = 16'd1; #1;
    check("R4", "back to back", wrStrobe, 1'b1);
    check("R5", "done at 1", donePulse, 1'b1);
    tick();
    wordCount = 16'd0; #1;
    check("R3", "stop at zero", wrStrobe, 1'b0);
    busAck = 1'b0;
    tick();
    check("R3", "zero stays idle", wrStrobe, 1'b0);
    idleChan();
  endtask

  task automatic testFill();
    modeCode = 3'b100; dirTx = 1'b1; bufFull = 1'b0; wordCount = 16'd0; chanEnable = 1'b1;
    tick();
    check("R11", "fill on enable", fillReq, 1'b1);
    check("R3", "no rd at zero count", rdStrobe, 1'b0);
    dirTx = 1'b0;
    tick();
    check("R11", "no fill on rx", fillReq, 1'b0);
    idleChan();
  endtask

  task automatic testPaced();
    modeCode = 3'b110; dirTx = 1'b1; bufFull = 1'b0; wordCount = 16'd5;
    extReq = 1'b0; chanEnable = 1'b1;
    tick(); tick();
    check("R6", "paced waits", rdStrobe, 1'b0);
    extReq = 1'b1;
    tick();
    check("R6", "paced start", rdStrobe, 1'b1);
    extReq = 1'b0; #1;
    check("R6", "strobe gated", rdStrobe, 1'b0);
    busAck = 1'b1; #1;
    check("R6", "no complete when gated", cntDec, 1'b0);
    tick();
    extReq = 1'b1; #1;
    check("R6", "strobe back", rdStrobe, 1'b1);
    check("R5", "paced dec", cntDec, 1'b1);
    tick();
    wordCount = 16'd4; #1;
    check("R4", "paced back to back", rdStrobe, 1'b1);
    chanEnable = 1'b0; #1;
    check("R12", "no dec when disabled", cntDec, 1'b0);
    busAck = 1'b0;
    tick();
    check("R12", "disable clears rd", rdStrobe, 1'b0);
    check("R12", "disable clears fill", fillReq, 1'b0);
    idleChan();
  endtask

  task automatic testHandshake();
    modeCode = 3'b010; dirTx = 1'b0; bufEmpty = 1'b0; wordCount = 16'd1;
    extReq = 1'b0; chanEnable = 1'b1;
    tick();
    check("R7", "no grant before edge", grantOut, 1'b0);
    extReq = 1'b1;
    tick();
    check("R7", "grant on edge", grantOut, 1'b1);
    check("R7", "no bus strobe", rdStrobe | wrStrobe, 1'b0);
    busAck = 1'b1; #1;
    check("R5", "hs done", donePulse, 1'b1);
    tick();
    wordCount = 16'd0; busAck = 1'b0;
    check("R7", "grant ends", grantOut, 1'b0);
    tick();
    check("R7", "one grant per edge", grantOut, 1'b0);
    extReq = 1'b0;
    tick();
    bufEmpty = 1'b1; extReq = 1'b1;
    tick();
    check("R7", "no grant when not ready", grantOut, 1'b0);
    idleChan();
  endtask

  task automatic testExtHandshake();
    modeCode = 3'b011; dirTx = 1'b0; bufEmpty = 1'b1; wordCount = 16'd3;
    extReq = 1'b0; chanEnable = 1'b1;
    tick();
    extReq = 1'b1;
    tick();
    check("R8", "xhs grant", grantOut, 1'b1);
    check("R8", "xhs no wr", wrStrobe, 1'b0);
    busAck = 1'b1; #1;
    check("R8", "xhs dec", cntDec, 1'b1);
    check("R5", "xhs no done", donePulse, 1'b0);
    tick();
    busAck = 1'b0;
    check("R8", "xhs grant ends", grantOut, 1'b0);
    idleChan();
  endtask

  task automatic testReserved();
    logic [2:0] codes [3];
    codes[0] = 3'b001; codes[1] = 3'b101; codes[2] = 3'b111;
    for (int i = 0; i < 3; i++) begin
      modeCode = codes[i]; chanEnable = 1'b1; dirTx = 1'b1; bufFull = 1'b0;
      bufEmpty = 1'b0; wordCount = 16'd3; extReq = 1'b0;
      tick();
      extReq = 1'b1;
      tick();
      check("R9", "reserved strobes", rdStrobe | wrStrobe | grantOut, 1'b0);
      check("R9", "reserved hostReq/fill", hostReq | fillReq, 1'b0);
      idleChan();
    end
  endtask

  task automatic testNoHs();
    modeCode = 3'b010; dirTx = 1'b0; bufEmpty = 1'b0; wordCount = 16'd3;
    extReq = 1'b0; chanEnable = 1'b1;
    tick();
    extReq = 1'b1;
    tick();
    check("R10", "no grant without capability", nhGrant, 1'b0);
    check("R7", "capable copy grants", grantOut, 1'b1);
    idleChan();
    modeCode = 3'b110; extReq = 1'b1; chanEnable = 1'b1;
    tick(); tick();
    check("R10", "paced off without capability", nhWr, 1'b0);
    modeCode = 3'b100;
    tick();
    check("R10", "master kept", nhWr, 1'b1);
    idleChan();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testSlave();
    testMaster();
    testFill();
    testPaced();
    testHandshake();
    testExtHandshake();
    testReserved();
    testNoHs();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule